// File: doc/BRIEF.md
# Micro-Operation Keccak Lane Engine

This block is an area-lean Keccak datapath. Every state lane and every intermediate value lives in one single-port RAM of 256 words by 64 bits. Nothing is held in wide registers. A host composes the permutation out of small steps. Each step is a 32-bit instruction that reads one or two lanes, combines them in a 64-bit ALU and writes one lane back.

An instruction is accepted on `start` while the engine is idle. A seven-state controller then selects the operation. For two-operand operations it fetches operand a first. It always fetches operand b, and it ends with one write-back cycle. While the controller is busy it owns the RAM. While it is idle, the host port reads and writes the RAM directly, and `busy` tells the host which side is in charge.

The instruction word is laid out as {dst[31:24], srcB[23:16], srcA[15:8], op[7:0]}. The operations are two-lane XOR and AND, NOT, XOR with a round constant, and the 25 fixed lane rotations. The destination may equal a source address, so a theta column parity can be accumulated in a single scratch word.

Top module: `keccak_uop_engine`

## Requirements
- R1: After reset, `busy` is 0 and the host port owns the RAM.
- R2: While `busy` is 0, a host write with `hostWe`=1 stores `hostWdata` at `hostAddr` on the clock edge. A read shows the word at `hostAddr` on `hostRdata` one clock after the address is presented.
- R3: Opcode 0 writes mem[srcA] XOR mem[srcB] to mem[dst].
- R4: Opcode 1 writes mem[srcA] AND mem[srcB] to mem[dst].
- R5: Opcode 2 writes the bitwise NOT of mem[srcB] to mem[dst].
- R6: Opcode 3 writes mem[srcB] XOR RC[k] to mem[dst]. Here k is instr[12:8] and RC[k] is the k-th Keccak iota round constant (RC[0]=0x1, RC[1]=0x8082, RC[23]=0x8000000080008008).
- R7: Opcodes 4 to 28 write mem[srcB] rotated left to mem[dst]. The rotation amount is the Keccak rho offset of lane number opcode-4, where the lane number is x+5y. For example, opcode 5 rotates by 1, opcode 6 by 62, opcode 10 by 44 and opcode 28 by 14, and opcode 4 leaves the word unchanged.
- R8: dst may equal srcA or srcB. The operands are read before the result is written, so chains of XORs can accumulate into one address.
- R9: An opcode above 28 holds `busy` for exactly one cycle and writes nothing.
- R10: `busy` rises on the clock edge that accepts `start`. It stays high for 6 cycles for opcodes 0 and 1, and for 4 cycles for opcodes 2 to 28.
- R11: While `busy` is 1, host writes do not change the RAM, and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept `instr` when idle |
| instr | input | 32 | Instruction {dst, srcB, srcA, op} |
| hostAddr | input | 8 | Host RAM address (used when idle) |
| hostWe | input | 1 | Host write enable (used when idle) |
| hostWdata | input | 64 | Host write data |
| hostRdata | output | 64 | RAM read data, one cycle after address |
| busy | output | 1 | 1 while the controller owns the RAM |

## Verification
Each operation class is run with operand words whose results are easy to tell apart. XOR and AND get overlapping bit patterns, so a swap between the two shows up. NOT and the constant XOR run on zero and on non-zero lanes. The rotations use an asymmetric word, so a wrong offset or a wrong direction gives a different value. A five-lane parity chain that writes back into its own source address catches any write that lands before the operand fetch. Out-of-range opcodes and host activity during a running instruction confirm that RAM words stay unchanged, and the length of each `busy` window separates the one-operand path from the two-operand path.

// File: rtl/kue_pkg.sv
package kue_pkg;
  localparam int LANE_W  = 64;
  localparam int ADDR_W  = 8;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 8;

  localparam logic [OP_W-1:0] OP_XOR  = 8'd0;
  localparam logic [OP_W-1:0] OP_AND  = 8'd1;
  localparam logic [OP_W-1:0] OP_NOT  = 8'd2;
  localparam logic [OP_W-1:0] OP_RCX  = 8'd3;
  localparam logic [OP_W-1:0] OP_ROT0 = 8'd4;
  localparam logic [OP_W-1:0] OP_LAST = 8'd28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHOOSE, ST_A_ADDR, ST_A_LOAD, ST_B_ADDR, ST_B_LOAD, ST_R_WRITE
  } ctrl_state_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadR;
  } strobe_t;

  // rho offset of lane x+5y, walked along the (x,y) -> (y,2x+3y) orbit
  function automatic logic [5:0] rhoOffset(input int lane);
    int x, y, nx, ny;
    logic [5:0] res;
    res = '0;
    x = 1;
    y = 0;
    for (int t = 0; t < 24; t++) begin
      if (lane != 0 && (x + 5*y) == lane) res = 6'(((t+1)*(t+2)/2) % 64);
      nx = y;
      ny = (2*x + 3*y) % 5;
      x = nx;
      y = ny;
    end
    return res;
  endfunction

  // iota round constant from the degree-8 LFSR
  function automatic logic [63:0] roundConst(input int idx);
    logic [7:0]  r;
    logic [63:0] rc;
    logic        msb;
    r  = 8'h01;
    rc = '0;
    for (int t = 0; t < 224; t++) begin
      if (t >= 7*idx && t < 7*idx + 7) rc[(1 << (t - 7*idx)) - 1] = r[0];
      msb = r[7];
      r   = {r[6:0], 1'b0};
      if (msb) r = r ^ 8'h71;
    end
    return rc;
  endfunction
endpackage

// File: rtl/kue_ram.sv
module kue_ram #(
  parameter int W  = 64,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/kue_ctrl.sv
module kue_ctrl
  import kue_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [IW-1:0] instr,
  output strobe_t       stb,
  output logic [AW-1:0] ramAddr,
  output logic          ramWe,
  output logic          busy,
  output logic [OP_W-1:0] opcode,
  output logic [4:0]    rcIdx
);
  ctrl_state_t state, nextState;
  logic [IW-1:0] instrReg;
  logic [AW-1:0] srcA, srcB, dst;

  assign opcode = instrReg[OP_W-1:0];
  assign srcA   = instrReg[OP_W +: AW];
  assign srcB   = instrReg[OP_W+AW +: AW];
  assign dst    = instrReg[OP_W+2*AW +: AW];
  assign rcIdx  = srcA[4:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      instrReg <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) instrReg <= instr;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (start) nextState = ST_CHOOSE;
      ST_CHOOSE: begin
        if (opcode <= OP_AND)       nextState = ST_A_ADDR;
        else if (opcode <= OP_LAST) nextState = ST_B_ADDR;
        else                        nextState = ST_IDLE;
      end
      ST_A_ADDR:  nextState = ST_A_LOAD;
      ST_A_LOAD:  nextState = ST_B_ADDR;
      ST_B_ADDR:  nextState = ST_B_LOAD;
      ST_B_LOAD:  nextState = ST_R_WRITE;
      ST_R_WRITE: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_A_ADDR:  ramAddr = srcA;
      ST_B_ADDR:  ramAddr = srcB;
      ST_R_WRITE: ramAddr = dst;
      default:    ramAddr = '0;
    endcase
  end

  assign ramWe     = (state == ST_R_WRITE);
  assign stb.loadA = (state == ST_A_LOAD);
  assign stb.loadB = (state == ST_B_LOAD);
  assign stb.loadR = (state == ST_R_WRITE);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/kue_alu.sv
module kue_alu
  import kue_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [W-1:0]    rdData,
  input  logic [OP_W-1:0] opcode,
  input  logic [4:0]      rcIdx,
  output logic [W-1:0]    wrData
);
  logic [W-1:0] regA, regB, result;
  logic [5:0]   rotAmt;
  logic [2*W-1:0] rotWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (stb.loadA) regA <= rdData;
      if (stb.loadB) regB <= rdData;
    end
  end

  always_comb begin
    rotAmt  = rhoOffset(int'(opcode) - int'(OP_ROT0));
    rotWide = {regB, regB} << rotAmt;
    unique case (opcode)
      OP_XOR:  result = regA ^ regB;
      OP_AND:  result = regA & regB;
      OP_NOT:  result = ~regB;
      OP_RCX:  result = regB ^ W'(roundConst(int'(rcIdx)));
      default: result = rotWide[2*W-1:W];
    endcase
  end

  assign wrData = stb.loadR ? result : '0;
endmodule

// File: rtl/keccak_uop_engine.sv
module keccak_uop_engine
  import kue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostWe,
  input  logic [LANE_W-1:0]  hostWdata,
  output logic [LANE_W-1:0]  hostRdata,
  output logic               busy
);
  strobe_t             stb;
  logic [ADDR_W-1:0]   ctrlAddr, ramAddr;
  logic                ctrlWe, ramWe;
  logic [OP_W-1:0]     opcode;
  logic [4:0]          rcIdx;
  logic [LANE_W-1:0]   aluWdata, ramWdata, ramRdata;

  kue_ctrl #(.IW(INSTR_W), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .stb(stb), .ramAddr(ctrlAddr), .ramWe(ctrlWe), .busy(busy),
    .opcode(opcode), .rcIdx(rcIdx)
  );

  kue_alu #(.W(LANE_W)) u_alu (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(ramRdata),
    .opcode(opcode), .rcIdx(rcIdx), .wrData(aluWdata)
  );

  assign ramAddr  = busy ? ctrlAddr : hostAddr;
  assign ramWe    = busy ? ctrlWe   : hostWe;
  assign ramWdata = busy ? aluWdata : hostWdata;

  kue_ram #(.W(LANE_W), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(ramWe), .addr(ramAddr), .wdata(ramWdata), .rdata(ramRdata)
  );

  assign hostRdata = ramRdata;
endmodule

// File: rtl/kue_checker.sv
module kue_checker
  import kue_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    start,
  input logic    busy,
  input strobe_t stb,
  input logic    ctrlWe
);
  // R10: accepting start makes the engine busy on the next cycle
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R10: only one ALU strobe at a time
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadA, stb.loadB, stb.loadR}));

  // R8: write-back always follows the operand-b capture
  a_r8_write_after_b: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadR |-> $past(stb.loadB));

  // R10: write-back is the last busy cycle
  a_r10_idle_after_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadR |=> !busy);

  // R1: the controller never writes while idle
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ctrlWe);
endmodule

bind keccak_uop_engine kue_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .stb(stb), .ctrlWe(ctrlWe)
);

// File: tb/keccak_uop_engine_bench.sv
module keccak_uop_engine_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [7:0]  hostAddr = '0;
  logic        hostWe = 1'b0;
  logic [63:0] hostWdata = '0;
  logic [63:0] hostRdata;
  logic        busy;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t expQ[$];

  logic rdFlag = 1'b0;
  logic rdValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keccak_uop_engine u_keccak_uop_engine (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .busy(busy)
  );

  always @(posedge clk) rdValid <= rdFlag;

  // monitor: compare each host read against the scoreboard
  always @(negedge clk) begin
    if (rdValid && expQ.size() > 0) begin
      exp_item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (hostRdata !== it.exp) begin
        nFail++;
        $display("FAIL %s: got %h expected %h", it.tag, hostRdata, it.exp);
      end
    end
  end

  function automatic logic [63:0] rotl(input logic [63:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
  endfunction

  function automatic logic [31:0] mk(input int op, input int a, input int b, input int d);
    return {8'(d), 8'(b), 8'(a), 8'(op)};
  endfunction

  task automatic checkVal(input string tag, input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input int addr, input logic [63:0] data);
    @(negedge clk);
    hostAddr = 8'(addr); hostWdata = data; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  // driver: push the expected word, then issue the read
  task automatic expectRam(input int addr, input logic [63:0] exp, input string tag);
    exp_item_t it;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    hostAddr = 8'(addr); rdFlag = 1'b1;
    @(negedge clk);
    rdFlag = 1'b0;
  endtask

  task automatic runOp(input logic [31:0] ins, output int cycles);
    @(negedge clk);
    instr = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R10: got hung expected completion");
    finishRun();
  end

  initial begin
    int cyc;
    logic [63:0] pA, pB, rv, par;
    pA = 64'hF0F0_1234_5678_AAAA;
    pB = 64'h0FF0_FFFF_0000_A5A5;
    rv = 64'h0123_4567_89AB_CDEF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 busy after reset", longint'(busy), 0);

    // R2 host access
    hostWrite(10, pA);
    hostWrite(11, pB);
    hostWrite(20, 64'h0);
    hostWrite(22, rv);
    expectRam(10, pA, "R2 host readback a");
    expectRam(11, pB, "R2 host readback b");

    // R3 XOR, R10 duration
    runOp(mk(0, 10, 11, 12), cyc);
    checkVal("R10 two-operand busy cycles", cyc, 6);
    expectRam(12, pA ^ pB, "R3 xor");

    // R4 AND
    runOp(mk(1, 10, 11, 13), cyc);
    expectRam(13, pA & pB, "R4 and");

    // R5 NOT, R10 single-operand duration
    runOp(mk(2, 0, 11, 14), cyc);
    checkVal("R10 one-operand busy cycles", cyc, 4);
    expectRam(14, ~pB, "R5 not");

    // R6 round constants
    runOp(mk(3, 0, 20, 21), cyc);
    expectRam(21, 64'h1, "R6 rc index 0");
    runOp(mk(3, 1, 20, 21), cyc);
    expectRam(21, 64'h8082, "R6 rc index 1");
    runOp(mk(3, 2, 20, 21), cyc);
    expectRam(21, 64'h8000_0000_0000_808A, "R6 rc index 2");
    runOp(mk(3, 23, 22, 21), cyc);
    expectRam(21, rv ^ 64'h8000_0000_8000_8008, "R6 rc index 23 on nonzero lane");

    // R7 rotations
    runOp(mk(4, 0, 22, 23), cyc);
    expectRam(23, rv, "R7 lane 0 offset 0");
    runOp(mk(5, 0, 22, 23), cyc);
    expectRam(23, rotl(rv, 1), "R7 lane 1 offset 1");
    runOp(mk(6, 0, 22, 23), cyc);
    expectRam(23, rotl(rv, 62), "R7 lane 2 offset 62");
    runOp(mk(10, 0, 22, 23), cyc);
    expectRam(23, rotl(rv, 44), "R7 lane 6 offset 44");
    runOp(mk(28, 0, 22, 23), cyc);
    expectRam(23, rotl(rv, 14), "R7 lane 24 offset 14");

    // R8 parity chain accumulating in address 40
    par = '0;
    for (int i = 0; i < 5; i++) begin
      hostWrite(30 + i, rv ^ (64'h1111_0000_0000_0001 << i) ^ 64'(i * 7919));
      par = par ^ rv ^ (64'h1111_0000_0000_0001 << i) ^ 64'(i * 7919);
    end
    runOp(mk(0, 30, 31, 40), cyc);
    for (int i = 2; i < 5; i++) runOp(mk(0, 40, 30 + i, 40), cyc);
    expectRam(40, par, "R8 theta parity chain");
    runOp(mk(5, 0, 40, 40), cyc);
    expectRam(40, rotl(par, 1), "R8 in-place rotate");

    // R9 invalid opcodes
    hostWrite(50, pA);
    runOp(mk(29, 0, 11, 50), cyc);
    checkVal("R9 opcode 29 busy cycles", cyc, 1);
    runOp(mk(255, 10, 11, 50), cyc);
    checkVal("R9 opcode 255 busy cycles", cyc, 1);
    expectRam(50, pA, "R9 no write on invalid opcode");

    // R11 host write and start while busy
    hostWrite(60, 64'hDEAD);
    hostWrite(61, 64'hBEEF);
    @(negedge clk);
    instr = mk(0, 10, 11, 62); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    hostAddr = 8'd60; hostWdata = 64'h5555; hostWe = 1'b1;
    instr = mk(2, 0, 11, 61); start = 1'b1;
    @(negedge clk);
    hostWe = 1'b0; start = 1'b0;
    cyc = 2;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    checkVal("R11 busy length unaffected by start", cyc, 6);
    expectRam(60, 64'hDEAD, "R11 host write ignored while busy");
    expectRam(61, 64'hBEEF, "R11 start ignored while busy");
    expectRam(62, pA ^ pB, "R11 running op completes");

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule